// File: doc/BRIEF.md
# MACsec Receive Frame Decapsulator

This block sits on the receive side of a link-layer security path, after the stage that decrypts frame contents. Frames enter as a 128-bit packet stream, one 16-byte beat per cycle, with start and end markers, a count of unused trailing bytes and a 6-bit error field. A frame is treated as protected when the two bytes after the source address carry the value 0x88E5 and bypass is off. For a protected frame the block removes the security tag between the source address and the decrypted region. It also removes the 16-byte integrity value at the end of the frame and closes the gaps, so the original EtherType, which opens the decrypted region, follows the source address again.

The position of the trailing integrity value is only known when the last beat arrives. The block therefore keeps the most recent 16 kept bytes in its re-packing buffer until the end of the frame. It then compares those bytes against the computed value given on a sideband input. A mismatch is flagged in the error field of the last output beat, and no bytes are dropped. The association number and packet number from the tag are presented on a sideband output before the first output beat of the frame, in time for a key lookup. Frames of any other type, and all frames while bypass is selected, leave the block unchanged.

Top module: `macsecRxDecap`

## Requirements
- R1: A frame whose bytes 12..13 are not 0x88E5 leaves the block byte for byte unchanged, with the same end byte count and the same per-beat error value.
- R2: When bytes 12..13 are 0x88E5 and bit 5 of byte 14 is clear (8-byte tag), the output frame is input bytes 0..11 followed by input bytes 20 up to the 17th-last byte.
- R3: When bit 5 of byte 14 is set (16-byte tag), the output frame is input bytes 0..11 followed by input bytes 28 up to the 17th-last byte.
- R4: With `cfgBypass` high at the start beat, a frame of type 0x88E5 also passes unchanged; the mode is taken per frame at its start beat.
- R5: For a protected frame, the last 16 input bytes are compared with `icvCalc` held on the end beat. Bit 0 of `outErr` on the output end beat is set exactly on mismatch. That beat also carries the OR of all input error values of the frame, and the earlier output beats of the frame carry an error value of 0.
- R6: For each protected frame, `secValid` is high for one cycle before the first output beat of that frame. With it, `secAn` equals bits 1..0 of byte 14 and `secPn` equals bytes 16..19, with byte 16 most significant.
- R7: Output bytes are packed from the most significant byte (byte 0 in bits 127..120). Each output frame has exactly one start beat and one end beat, every beat but the end beat is full, and `outEmpty` gives the unused low bytes of the end beat.
- R8: `inReady` is low for exactly one cycle after a protected end beat whose remaining output needs two beats, and is high otherwise.
- R9: During reset `outValid` and `secValid` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgBypass | input | 1 | Pass all frames unchanged, sampled at each start beat |
| inValid | input | 1 | Input beat present |
| inReady | output | 1 | Block accepts a beat this cycle |
| inSop | input | 1 | First beat of an input frame |
| inEop | input | 1 | Last beat of an input frame |
| inData | input | 128 | Input bytes, byte 0 in the top bits |
| inEmpty | input | 4 | Unused low bytes of the input end beat |
| inErr | input | 6 | Input error field |
| icvCalc | input | 128 | Computed integrity value, held on the input end beat |
| outValid | output | 1 | Output beat present |
| outSop | output | 1 | First beat of an output frame |
| outEop | output | 1 | Last beat of an output frame |
| outData | output | 128 | Output bytes, byte 0 in the top bits |
| outEmpty | output | 4 | Unused low bytes of the output end beat |
| outErr | output | 6 | Output error field, bit 0 flags an integrity mismatch |
| secValid | output | 1 | One-cycle strobe for the tag fields |
| secAn | output | 2 | Association number of the current frame |
| secPn | output | 32 | Packet number of the current frame |

## Verification
Protected frames are sent with both tag lengths and with lengths that step byte by byte through more than two beats. The sweep moves the end of the kept region across every byte lane. This separates a correct re-packing from one that only works when the gap or trailer falls on a beat boundary, and it sets off the two-beat drain at the end of a frame and also avoids it. Frames with a matching and a mismatching computed value, some also carrying input error bits, separate the integrity flag from plain error forwarding. Frames of another EtherType and 0x88E5 frames under bypass show that recognition and mode selection are taken from the right bytes at the start beat. The tag fields seen on the sideband are matched against the values written into each frame, and their timing against that frame's first output beat.

// File: rtl/macsecRxPkg.sv
package macsecRxPkg;
  localparam int BEAT_BYTES   = 16;
  localparam int DATA_W       = BEAT_BYTES * 8;
  localparam int EMPTY_W      = $clog2(BEAT_BYTES);
  localparam int CNT_W        = $clog2(BEAT_BYTES) + 1;
  localparam int ERR_W        = 6;
  localparam int AUTH_ERR_BIT = 0;
  localparam int ICV_BYTES    = 16;
  localparam int MAC_HDR      = 12;
  localparam int SHORT_TAG    = 8;
  localparam int LONG_TAG     = 16;
  localparam int SC_BIT       = 5;
  localparam int AN_W         = 2;
  localparam int PN_W         = 32;
  localparam logic [15:0] PROT_ETYPE = 16'h88E5;

  // Per-beat command from control to datapath
  typedef struct packed {
    logic             take;      // protected beat accepted
    logic             pass;      // unchanged beat accepted
    logic             last;      // end beat of frame
    logic [CNT_W-1:0] dropLead;  // leading bytes removed from this beat
    logic [CNT_W-1:0] keepCnt;   // bytes kept after the removed ones
  } dpCmd_t;
endpackage

// File: rtl/macsecRxCtrl.sv
module macsecRxCtrl
  import macsecRxPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgBypass,
  input  logic              inValid,
  input  logic              inReady,
  input  logic              inSop,
  input  logic              inEop,
  input  logic [DATA_W-1:0] inData,
  input  logic [EMPTY_W-1:0] inEmpty,
  output dpCmd_t            cmd,
  output logic              secValid,
  output logic [AN_W-1:0]   secAn,
  output logic [PN_W-1:0]   secPn
);
  localparam int HDR_TAIL = BEAT_BYTES - MAC_HDR;  // tag bytes inside beat 0

  logic [1:0]      beatIdx;
  logic            protFrame, longTag, take, protNow, longNow, isBeat1;
  logic [15:0]     etype;
  logic [7:0]      tci;
  logic [AN_W-1:0] anHold;

  always_comb begin
    take    = inValid && inReady;
    etype   = inData[DATA_W-1-8*MAC_HDR -: 16];
    tci     = inData[DATA_W-1-8*(MAC_HDR+2) -: 8];
    protNow = inSop ? (!cfgBypass && etype == PROT_ETYPE) : protFrame;
    longNow = inSop ? tci[SC_BIT] : longTag;
    isBeat1 = !inSop && beatIdx == 2'd1;
    cmd.take = take && protNow;
    cmd.pass = take && !protNow;
    cmd.last = inEop;
    if (inSop) begin
      cmd.dropLead = '0;
      cmd.keepCnt  = CNT_W'(MAC_HDR);
    end else if (isBeat1) begin
      cmd.dropLead = longNow ? CNT_W'(LONG_TAG - HDR_TAIL) : CNT_W'(SHORT_TAG - HDR_TAIL);
      cmd.keepCnt  = CNT_W'(BEAT_BYTES) - cmd.dropLead;
    end else begin
      cmd.dropLead = '0;
      cmd.keepCnt  = inEop ? CNT_W'(BEAT_BYTES) - CNT_W'(inEmpty) : CNT_W'(BEAT_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatIdx   <= '0;
      protFrame <= 1'b0;
      longTag   <= 1'b0;
      anHold    <= '0;
      secValid  <= 1'b0;
      secAn     <= '0;
      secPn     <= '0;
    end else begin
      secValid <= 1'b0;
      if (take) begin
        if (inSop) begin
          beatIdx   <= 2'd1;
          protFrame <= protNow;
          longTag   <= longNow;
          anHold    <= tci[AN_W-1:0];
        end else if (beatIdx == 2'd1) begin
          beatIdx <= 2'd2;
          if (protFrame) begin
            secValid <= 1'b1;
            secAn    <= anHold;
            secPn    <= inData[DATA_W-1 -: PN_W];
          end
        end
      end
    end
  end

  assert_sec_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    secValid |=> !secValid);
endmodule

// File: rtl/macsecRxDatapath.sv
module macsecRxDatapath
  import macsecRxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [DATA_W-1:0]  inData,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic [ERR_W-1:0]   inErr,
  input  logic [DATA_W-1:0]  icvCalc,
  output logic               drainBusy,
  output logic               outValid,
  output logic               outSop,
  output logic               outEop,
  output logic [DATA_W-1:0]  outData,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic [ERR_W-1:0]   outErr
);
  localparam int BUF_BYTES = 3 * BEAT_BYTES;
  localparam int BUF_W     = BUF_BYTES * 8;
  localparam int FILL_W    = $clog2(BUF_BYTES + 1);

  logic [BUF_W-1:0]   bufReg, newWide, appended, icvAligned;
  logic [FILL_W-1:0]  fill, appFill, payload;
  logic [DATA_W-1:0]  keepMask, newBytes, icvRx, drainData;
  logic [EMPTY_W-1:0] drainEmpty;
  logic [ERR_W-1:0]   errAcc, errNow, eopErr, drainErr;
  logic               firstOut, authFail;

  always_comb begin
    keepMask   = ~({DATA_W{1'b1}} >> {cmd.keepCnt, 3'b000});
    newBytes   = (inData << {cmd.dropLead, 3'b000}) & keepMask;
    newWide    = {newBytes, {(BUF_W-DATA_W){1'b0}}} >> {fill, 3'b000};
    appended   = bufReg | newWide;
    appFill    = fill + FILL_W'(cmd.keepCnt);
    payload    = appFill - FILL_W'(ICV_BYTES);
    icvAligned = appended << {payload, 3'b000};
    icvRx      = icvAligned[BUF_W-1 -: DATA_W];
    authFail   = icvRx != icvCalc;
    errNow     = errAcc | inErr;
    eopErr     = errNow | (ERR_W'(authFail) << AUTH_ERR_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufReg <= '0; fill <= '0; errAcc <= '0; firstOut <= 1'b1;
      drainBusy <= 1'b0; drainData <= '0; drainEmpty <= '0; drainErr <= '0;
      outValid <= 1'b0; outSop <= 1'b0; outEop <= 1'b0;
      outData <= '0; outEmpty <= '0; outErr <= '0;
    end else begin
      outValid <= 1'b0; outSop <= 1'b0; outEop <= 1'b0;
      outEmpty <= '0; outErr <= '0;
      if (drainBusy) begin
        outValid  <= 1'b1;
        outEop    <= 1'b1;
        outData   <= drainData;
        outEmpty  <= drainEmpty;
        outErr    <= drainErr;
        drainBusy <= 1'b0;
      end else if (cmd.pass) begin
        outValid <= 1'b1;
        outSop   <= inSop;
        outEop   <= inEop;
        outData  <= inData;
        outEmpty <= inEmpty;
        outErr   <= inErr;
      end else if (cmd.take) begin
        if (cmd.last) begin
          outValid <= 1'b1;
          outSop   <= firstOut;
          outData  <= appended[BUF_W-1 -: DATA_W];
          if (payload > FILL_W'(BEAT_BYTES)) begin
            drainBusy  <= 1'b1;
            drainData  <= appended[BUF_W-DATA_W-1 -: DATA_W];
            drainEmpty <= EMPTY_W'(FILL_W'(2*BEAT_BYTES) - payload);
            drainErr   <= eopErr;
          end else begin
            outEop   <= 1'b1;
            outEmpty <= EMPTY_W'(FILL_W'(BEAT_BYTES) - payload);
            outErr   <= eopErr;
          end
          bufReg   <= '0;
          fill     <= '0;
          errAcc   <= '0;
          firstOut <= 1'b1;
        end else begin
          errAcc <= errNow;
          if (appFill >= FILL_W'(2*BEAT_BYTES)) begin
            outValid <= 1'b1;
            outSop   <= firstOut;
            outData  <= appended[BUF_W-1 -: DATA_W];
            firstOut <= 1'b0;
            bufReg   <= appended << DATA_W;
            fill     <= appFill - FILL_W'(BEAT_BYTES);
          end else begin
            bufReg <= appended;
            fill   <= appFill;
          end
        end
      end
    end
  end

  // Held-back bytes never exceed one beat plus the trailer window
  assert_buf_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    fill < FILL_W'(2*BEAT_BYTES));
  // A drain lasts one cycle and always produces the end beat
  assert_drain_one_R8: assert property (@(posedge clk) disable iff (!rstN)
    drainBusy |=> (!drainBusy && outValid && outEop));
endmodule

// File: rtl/macsecRxDecap.sv
module macsecRxDecap
  import macsecRxPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgBypass,
  input  logic               inValid,
  output logic               inReady,
  input  logic               inSop,
  input  logic               inEop,
  input  logic [DATA_W-1:0]  inData,
  input  logic [EMPTY_W-1:0] inEmpty,
  input  logic [ERR_W-1:0]   inErr,
  input  logic [DATA_W-1:0]  icvCalc,
  output logic               outValid,
  output logic               outSop,
  output logic               outEop,
  output logic [DATA_W-1:0]  outData,
  output logic [EMPTY_W-1:0] outEmpty,
  output logic [ERR_W-1:0]   outErr,
  output logic               secValid,
  output logic [AN_W-1:0]    secAn,
  output logic [PN_W-1:0]    secPn
);
  dpCmd_t cmd;
  logic   drainBusy;

  assign inReady = !drainBusy;

  macsecRxCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .inValid(inValid),
    .inReady(inReady), .inSop(inSop), .inEop(inEop), .inData(inData),
    .inEmpty(inEmpty), .cmd(cmd), .secValid(secValid), .secAn(secAn), .secPn(secPn)
  );

  macsecRxDatapath i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .inSop(inSop), .inEop(inEop),
    .inData(inData), .inEmpty(inEmpty), .inErr(inErr), .icvCalc(icvCalc),
    .drainBusy(drainBusy), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outData(outData), .outEmpty(outEmpty), .outErr(outErr)
  );

  // Output framing tracker for the checks below
  logic outOpen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outOpen <= 1'b0;
    else if (outValid && outEop) outOpen <= 1'b0;
    else if (outValid && outSop) outOpen <= 1'b1;
  end

  assert_sop_closed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outSop) |-> !outOpen);
  assert_cont_open_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outSop) |-> outOpen);
  assert_marks_valid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outSop || outEop) |-> outValid);
  assert_ready_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady);
endmodule

// File: tb/test_macsecRxDecap.sv
`timescale 1ns/1ps
module test_macsecRxDecap;
  logic         clk = 1'b0;
  logic         rstN, cfgBypass, inValid, inReady, inSop, inEop;
  logic [127:0] inData, icvCalc, outData;
  logic [3:0]   inEmpty, outEmpty;
  logic [5:0]   inErr, outErr;
  logic         outValid, outSop, outEop, secValid;
  logic [1:0]   secAn;
  logic [31:0]  secPn;

  always #4 clk = ~clk;

  macsecRxDecap i_macsecRxDecap (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .inValid(inValid), .inReady(inReady),
    .inSop(inSop), .inEop(inEop), .inData(inData), .inEmpty(inEmpty), .inErr(inErr),
    .icvCalc(icvCalc), .outValid(outValid), .outSop(outSop), .outEop(outEop),
    .outData(outData), .outEmpty(outEmpty), .outErr(outErr), .secValid(secValid),
    .secAn(secAn), .secPn(secPn)
  );

  int compared = 0, mismatched = 0;

  // Scoreboard queues
  logic [7:0]  expBytes[$];
  int          expLen[$];
  logic [5:0]  expErr[$];
  bit          expProt[$];
  string       expTag[$];
  logic [1:0]  expAn[$];
  logic [31:0] expPn[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic putBeat(input logic [127:0] d, input bit s, input bit e,
                         input logic [3:0] emp, input logic [5:0] er);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inData = d; inSop = s; inEop = e; inEmpty = emp; inErr = er;
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
  endtask

  task automatic sendFrame(input int len, input logic [15:0] etype, input bit longT,
                           input bit badIcv, input bit byp, input logic [5:0] errIn,
                           input logic [1:0] an, input logic [31:0] pn, input string tag);
    logic [7:0]   b[];
    logic [127:0] icv, d;
    bit           prot, drain;
    int           g, nb, s, cnt, k;
    b = new[len];
    for (int i = 0; i < len; i++) b[i] = 8'(i * 7 + len * 3 + 5);
    b[12] = etype[15:8]; b[13] = etype[7:0];
    prot = !byp && etype == 16'h88E5;
    if (etype == 16'h88E5) begin
      b[14] = (longT ? 8'h20 : 8'h00) | 8'h08 | {6'd0, an};
      b[15] = 8'h00;
      b[16] = pn[31:24]; b[17] = pn[23:16]; b[18] = pn[15:8]; b[19] = pn[7:0];
    end
    for (int i = 0; i < 16; i++) icv[127-8*i -: 8] = b[len-16+i];
    g = longT ? 16 : 8;
    if (prot) begin
      expLen.push_back(len - g - 16);
      for (int i = 0; i < 12; i++) expBytes.push_back(b[i]);
      for (int i = 12 + g; i < len - 16; i++) expBytes.push_back(b[i]);
      expErr.push_back(errIn | (badIcv ? 6'h01 : 6'h00));
      expAn.push_back(an); expPn.push_back(pn);
    end else begin
      expLen.push_back(len);
      for (int i = 0; i < len; i++) expBytes.push_back(b[i]);
      expErr.push_back(errIn);
    end
    expProt.push_back(prot); expTag.push_back(tag);
    nb  = (len + 15) / 16;
    s   = 12 + (longT ? 4 : 12) + 16 * (nb - 3);
    cnt = 16 + ((s - 16) % 16);
    k   = len - 16 * (nb - 1);
    drain = prot && (cnt + k > 32);
    cfgBypass = byp;
    icvCalc   = badIcv ? (icv ^ 128'h1) : icv;
    for (int bi = 0; bi < nb; bi++) begin
      for (int j = 0; j < 16; j++) d[127-8*j -: 8] = (16*bi + j < len) ? b[16*bi + j] : 8'h00;
      putBeat(d, bi == 0, bi == nb - 1, (bi == nb - 1) ? 4'(16*nb - len) : 4'd0,
              (bi == 1) ? errIn : 6'd0);
    end
    chk(inReady == !drain, "R8", "inReady after end beat", inReady, !drain);
  endtask

  // Monitor
  logic [7:0] got[$];
  logic [5:0] gotErr;
  bit         open = 0;
  int         secCnt = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (secValid) begin
        secCnt++;
        if (expAn.size() == 0) chk(0, "R6", "unexpected secValid", 1, 0);
        else begin
          logic [1:0]  a;
          logic [31:0] p;
          a = expAn.pop_front(); p = expPn.pop_front();
          chk(secAn == a, "R6", "secAn", secAn, a);
          chk(secPn == p, "R6", "secPn", secPn, p);
        end
      end
      if (outValid) begin
        if (outSop) begin
          chk(!open, "R7", "start beat inside frame", open, 0);
          open = 1; got.delete(); gotErr = '0;
          if (expProt.size() > 0 && expProt[0]) begin
            chk(secCnt > 0, "R6", "sideband before first beat", secCnt, 1);
            if (secCnt > 0) secCnt--;
          end
        end
        if (!outEop && expProt.size() > 0 && expProt[0])
          chk(outErr == 0, "R5", "error on non-end beat", outErr, 0);
        for (int j = 0; j < (outEop ? 16 - outEmpty : 16); j++) got.push_back(outData[127-8*j -: 8]);
        gotErr = gotErr | outErr;
        if (outEop) begin
          open = 0;
          if (expLen.size() == 0) chk(0, "R7", "unexpected frame", 1, 0);
          else begin
            int         n, bad;
            logic [7:0] eb;
            logic [5:0] ee;
            string      t;
            n = expLen.pop_front(); ee = expErr.pop_front(); t = expTag.pop_front();
            void'(expProt.pop_front());
            chk(got.size() == n, t, "frame length", got.size(), n);
            bad = -1;
            for (int i = 0; i < n; i++) begin
              eb = expBytes.pop_front();
              if (i < got.size() && bad < 0 && got[i] != eb) bad = i;
            end
            chk(bad < 0, t, "frame bytes first bad index", bad, -1);
            chk(gotErr == ee, t, "error field", gotErr, ee);
          end
        end
      end
    end
  end

  initial begin
    rstN = 1'b0; cfgBypass = 1'b0; inValid = 1'b0; inSop = 1'b0; inEop = 1'b0;
    inData = '0; inEmpty = '0; inErr = '0; icvCalc = '0;
    repeat (3) @(negedge clk);
    chk(outValid == 0, "R9", "outValid in reset", outValid, 0);
    chk(secValid == 0, "R9", "secValid in reset", secValid, 0);
    chk(inReady == 1, "R9", "inReady in reset", inReady, 1);
    rstN = 1'b1;
    @(negedge clk);
    sendFrame(64, 16'h88E5, 0, 0, 0, 6'h00, 2'd1, 32'h0000_1001, "R2");
    sendFrame(80, 16'h88E5, 1, 0, 0, 6'h00, 2'd2, 32'hA5A5_0002, "R3");
    sendFrame(46, 16'h88E5, 1, 0, 0, 6'h00, 2'd3, 32'h1234_5678, "R3");
    sendFrame(38, 16'h88E5, 0, 0, 0, 6'h00, 2'd0, 32'hFFFF_FFFE, "R2");
    sendFrame(72, 16'h88E5, 0, 1, 0, 6'h00, 2'd1, 32'h0000_0010, "R5");
    sendFrame(90, 16'h88E5, 1, 1, 0, 6'h24, 2'd2, 32'h0000_0011, "R5");
    sendFrame(66, 16'h88E5, 0, 0, 0, 6'h0C, 2'd3, 32'h0000_0012, "R5");
    sendFrame(70, 16'h0800, 0, 0, 0, 6'h02, 2'd0, 32'h0, "R1");
    sendFrame(60, 16'h88E5, 0, 0, 1, 6'h00, 2'd1, 32'h0000_0020, "R4");
    sendFrame(52, 16'h88E5, 1, 1, 1, 6'h00, 2'd2, 32'h0000_0021, "R4");
    for (int l = 48; l < 80; l++)
      sendFrame(l, 16'h88E5, l[0], 0, 0, 6'h00, 2'(l), 32'(l * 1000), "R7");
    for (int w = 0; w < 50 && expLen.size() > 0; w++) @(negedge clk);
    chk(expLen.size() == 0, "R7", "frames left unseen", expLen.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R7 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule